// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block turns 32-bit device virtual addresses into physical addresses. A 4 KiB page keeps its low 12 address bits unchanged. The upper 20 bits are resolved through a two-level table in memory. The top ten bits pick an entry in the first-level table. That entry names the page frame of a second-level table. Bits 21 down to 12 then pick the entry in that table that names the data page frame.

Recent translations are kept in a small fully associative cache. A hit is answered on the next cycle. On a miss the unit performs a walk with two dependent memory reads. While the walk runs, the request port is held not-ready.

The tables carry no valid bit. Unmapped regions point at a shared dummy second-level table and a dummy page, so every translation completes. A small register port sets the table base and an info word, and a register write flushes the whole cache.

Top module: `xlt_unit`

## Requirements
- R1: After reset no cache entry is valid, `req_ready` is 1, `rsp_valid` and `mem_rd_en` are 0, and both the base register (offset 0x4) and the info register (offset 0x8) read as 0.
- R2: Offset 0x4 holds the first-level table base as a 27-bit frame number; a write keeps `wdata[26:0]` and a read returns it zero-extended. Offset 0x8 reads back the last 32-bit value written.
- R3: On a miss exactly two reads are issued, one at a time. The first is at `{base[19:0], va[31:22], 2'b00}`. The second is at `{E1[19:0], va[21:12], 2'b00}`, where E1 is the first read's data. The result is `{E2[19:0], va[11:0]}`, where E2 is the second read's data.
- R4: A request that misses drops `req_ready` from the cycle after acceptance until its response has been given.
- R5: A request whose page is cached gets `rsp_valid` one cycle after acceptance with the cached frame and the request's offset, and issues no memory read.
- R6: Addresses with no mapping still finish a normal walk and return whatever frame the dummy entries hold; there is no fault path.
- R7: The cache holds 4 pages tagged by `va[31:12]`. New fills go to slots in round-robin order, so the fifth distinct page evicts the oldest fill.
- R8: Writing 0xFFFFFFFF to offset 0x0 invalidates every entry by the next cycle. Writing any other value to offset 0x0 changes nothing.
- R9: A request accepted in the same cycle as an invalidate write is not answered from the cache; it walks.
- R10: An invalidate during a walk still lets that walk return its correct result to the requester, but the result is not stored in the cache.
- R11: Back-to-back invalidate writes, and a base-register read immediately followed by an invalidate write, leave the unit serving requests normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle pulse with the translated address |
| rsp_paddr | output | 32 | Physical address |
| mem_rd_en | output | 1 | Table-entry read request (one cycle) |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Table entry (frame number in bits 19:0) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 invalidate, 0x4 base, 0x8 info) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
Translations are run against a bench memory that has two real second-level tables, a dummy table and a dummy page. Cold misses, repeated pages with new offsets, and unmapped addresses at both levels are all tried. The count of memory reads and the response latency together tell a hit (zero reads, one cycle) from a walk (two reads at computed addresses). A sweep of five distinct pages separates round-robin eviction from other orders. Invalidates are placed before a request, on the very cycle of acceptance, in the middle of a walk and back to back. Each case is judged by whether the next lookup of the same page walks again.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_L1_RD,
    WK_L1_WT,
    WK_L2_RD,
    WK_L2_WT
  } walk_state_e;

  localparam logic [3:0] OFF_INVAL = 4'h0;
  localparam logic [3:0] OFF_BASE  = 4'h4;
  localparam logic [3:0] OFF_INFO  = 4'h8;
endpackage

// File: rtl/xlt_regs.sv
module xlt_regs
  import xlt_pkg::*;
#(
  parameter int BASE_W = 27,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BASE_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] info_q, info_d;
  logic              base_we, info_we;

  always_comb begin
    base_we = wr_en_i && (addr_i == OFF_BASE);
    info_we = wr_en_i && (addr_i == OFF_INFO);
    base_d  = base_we ? wdata_i[BASE_W-1:0] : base_q;
    info_d  = info_we ? wdata_i : info_q;
    flush_o = wr_en_i && (addr_i == OFF_INVAL) && (&wdata_i);
    rdata_o = '0;
    case (addr_i)
      OFF_BASE: rdata_o = DATA_W'(base_q);
      OFF_INFO: rdata_o = info_q;
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      info_q <= '0;
    end else begin
      base_q <= base_d;
      info_q <= info_d;
    end
  end

  assign base_o = base_q;

  assert_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFF_BASE) |=> (base_o == $past(wdata_i[BASE_W-1:0])));
endmodule

// File: rtl/xlt_walk.sv
module xlt_walk
  import xlt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [OFF_W-3:0]        idx1_i,
  input  logic [OFF_W-3:0]        idx2_i,
  input  logic [ADDR_W-OFF_W-1:0] base_pfn_i,
  output logic                    mem_rd_en_o,
  output logic [ADDR_W-1:0]       mem_rd_addr_o,
  input  logic                    mem_rd_valid_i,
  input  logic [ADDR_W-1:0]       mem_rd_data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [ADDR_W-OFF_W-1:0] done_pfn_o
);
  localparam int IDX_W = OFF_W - 2;
  localparam int PFN_W = ADDR_W - OFF_W;

  walk_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx1_q, idx1_d, idx2_q, idx2_d;
  logic [PFN_W-1:0] l1_pfn_q, l1_pfn_d;
  logic             take;
  logic             unused_hi;

  assign unused_hi = ^mem_rd_data_i[ADDR_W-1:PFN_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:  if (start_i) state_d = WK_L1_RD;
      WK_L1_RD: state_d = WK_L1_WT;
      WK_L1_WT: if (mem_rd_valid_i) state_d = WK_L2_RD;
      WK_L2_RD: state_d = WK_L2_WT;
      WK_L2_WT: if (mem_rd_valid_i) state_d = WK_IDLE;
      default:  state_d = WK_IDLE;
    endcase
    take     = start_i && (state_q == WK_IDLE);
    idx1_d   = take ? idx1_i : idx1_q;
    idx2_d   = take ? idx2_i : idx2_q;
    l1_pfn_d = (state_q == WK_L1_WT && mem_rd_valid_i) ? mem_rd_data_i[PFN_W-1:0] : l1_pfn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    idx1_q   <= idx1_d;
    idx2_q   <= idx2_d;
    l1_pfn_q <= l1_pfn_d;
  end

  assign mem_rd_en_o   = (state_q == WK_L1_RD) || (state_q == WK_L2_RD);
  assign mem_rd_addr_o = (state_q == WK_L2_RD) ? {l1_pfn_q, idx2_q, 2'b00}
                                               : {base_pfn_i, idx1_q, 2'b00};
  assign busy_o        = (state_q != WK_IDLE);
  assign done_o        = (state_q == WK_L2_WT) && mem_rd_valid_i;
  assign done_pfn_o    = mem_rd_data_i[PFN_W-1:0];

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> !mem_rd_en_o);
  assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
  parameter int TAG_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  input  logic             flush_i,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_d, hit_vec;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               do_fill;

  always_comb begin
    hit_pfn_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = valid_q[i] && (tag_q[i] == lk_tag_i);
      if (hit_vec[i]) hit_pfn_o = hit_pfn_o | pfn_q[i];
    end
    hit_o   = |hit_vec;
    do_fill = fill_en_i && !flush_i;
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (flush_i) begin
      valid_d = '0;
    end else if (fill_en_i) begin
      valid_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_fill && ptr_q == PTR_W'(g)) begin
        tag_q[g] <= fill_tag_i;
        pfn_q[g] <= fill_pfn_i;
      end
    end
  end

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));
  assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_rr_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/xlt_unit.sv
module xlt_unit #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int TLB_ENTRIES = 4,
  parameter int BASE_W      = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int PFN_W = ADDR_W - OFF_W;
  localparam int IDX_W = OFF_W - 2;

  logic              flush, busy, walk_done, tlb_hit;
  logic              accept, use_hit, start, fill_en;
  logic [BASE_W-1:0] base;
  logic [PFN_W-1:0]  done_pfn, tlb_pfn, tag_q, tag_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              drop_q, drop_d, rsp_valid_d;
  logic [ADDR_W-1:0] rsp_paddr_d;
  logic              unused_base;

  assign unused_base = ^base[BASE_W-1:PFN_W];

  xlt_regs #(.BASE_W(BASE_W), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .base_o(base), .flush_o(flush), .rdata_o(reg_rdata)
  );

  xlt_tlb #(.TAG_W(PFN_W), .PFN_W(PFN_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_tag_i(req_vaddr[ADDR_W-1:OFF_W]),
    .hit_o(tlb_hit), .hit_pfn_o(tlb_pfn), .flush_i(flush),
    .fill_en_i(fill_en), .fill_tag_i(tag_q), .fill_pfn_i(done_pfn)
  );

  xlt_walk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .idx1_i(req_vaddr[ADDR_W-1 -: IDX_W]), .idx2_i(req_vaddr[OFF_W +: IDX_W]),
    .base_pfn_i(base[PFN_W-1:0]), .mem_rd_en_o(mem_rd_en),
    .mem_rd_addr_o(mem_rd_addr), .mem_rd_valid_i(mem_rd_valid),
    .mem_rd_data_i(mem_rd_data), .busy_o(busy), .done_o(walk_done),
    .done_pfn_o(done_pfn)
  );

  always_comb begin
    req_ready   = !busy;
    accept      = req_valid && req_ready;
    use_hit     = accept && tlb_hit && !flush;
    start       = accept && !use_hit;
    fill_en     = walk_done && !drop_q && !flush;
    tag_d       = start ? req_vaddr[ADDR_W-1:OFF_W] : tag_q;
    off_d       = start ? req_vaddr[OFF_W-1:0] : off_q;
    drop_d      = start ? 1'b0 : ((flush && busy) ? 1'b1 : drop_q);
    rsp_valid_d = use_hit || walk_done;
    rsp_paddr_d = use_hit ? {tlb_pfn, req_vaddr[OFF_W-1:0]} : {done_pfn, off_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      drop_q    <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    tag_q     <= tag_d;
    off_q     <= off_d;
    if (rsp_valid_d) rsp_paddr <= rsp_paddr_d;
  end

  assert_hit_next_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tlb_hit && !flush) |=> rsp_valid);
  assert_miss_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(tlb_hit && !flush)) |=> !req_ready);
  assert_flush_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !tlb_hit);
  assert_walk_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid);
endmodule

// File: tb/xlt_unit_bench.sv
`timescale 1ns/1ps
module xlt_unit_bench;
  localparam logic [19:0] BASE_PFN = 20'h00040;
  localparam logic [19:0] DUMMY_L2 = 20'h000FF;
  localparam logic [19:0] DUMMY_PG = 20'h000DD;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, rsp_valid;
  logic [31:0] req_vaddr, rsp_paddr;
  logic mem_rd_en, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic reg_wr_en;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [31:0] prev_addr, last_addr;
  logic [1:0]  pend_v = 2'b00;
  logic [31:0] pend_a0, pend_a1;

  always #2.5 clk = ~clk;

  xlt_unit u_xlt_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    logic [19:0] pfn;
    logic [9:0]  idx;
    pfn = a[31:12];
    idx = a[11:2];
    if (pfn == BASE_PFN)
      return (idx == 10'd1 || idx == 10'd5) ? 32'h100 + 32'(idx) : {12'hF00, DUMMY_L2};
    if (pfn == 20'h00101 || pfn == 20'h00105)
      return (idx < 10'd16) ? 32'h2000 + (32'(pfn[3:0]) << 8) + 32'(idx) : {12'hA00, DUMMY_PG};
    if (pfn == DUMMY_L2) return {12'h500, DUMMY_PG};
    return 32'h0000_0BAD;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    logic [31:0] e1, e2;
    e1 = model_rd({BASE_PFN, va[31:22], 2'b00});
    e2 = model_rd({e1[19:0], va[21:12], 2'b00});
    return {e2[19:0], va[11:0]};
  endfunction

  // memory responder: data two cycles after the read request
  always @(negedge clk) begin
    mem_rd_valid = pend_v[1];
    mem_rd_data  = model_rd(pend_a1);
    pend_v[1] = pend_v[0];
    pend_a1   = pend_a0;
    pend_v[0] = (mem_rd_en === 1'b1);
    pend_a0   = mem_rd_addr;
    if (mem_rd_en === 1'b1) begin
      rd_count++;
      prev_addr = last_addr;
      last_addr = mem_rd_addr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_rsp(input int r0, output logic [31:0] pa, output int reads, output int lat);
    lat = 1;
    while (rsp_valid !== 1'b1 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (rsp_valid !== 1'b1) check(1'b0, "R3 response timeout", 32'(lat), 32'd0);
    pa = rsp_paddr;
    reads = rd_count - r0;
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa, output int reads, output int lat);
    int r0;
    int guard;
    @(negedge clk);
    r0 = rd_count;
    req_valid = 1'b1; req_vaddr = va;
    guard = 0;
    while (req_ready !== 1'b1 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(r0, pa, reads, lat);
  endtask

  function automatic logic [31:0] page(input int j, input logic [11:0] off);
    return 32'h0040_0000 | (32'(j) << 12) | 32'(off);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_rd_en === 1'b0, "R1 mem_rd_en", 32'(mem_rd_en), 32'd0);
    reg_read(4'h4, d);
    check(d === 32'd0, "R1 base reset", d, 32'd0);
    reg_read(4'h8, d);
    check(d === 32'd0, "R1 info reset", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(4'h4, 32'hFFFF_FFFF);
    reg_read(4'h4, d);
    check(d === 32'h07FF_FFFF, "R2 base width", d, 32'h07FF_FFFF);
    reg_write(4'h8, 32'hA5C3_0F1E);
    reg_read(4'h8, d);
    check(d === 32'hA5C3_0F1E, "R2 info readback", d, 32'hA5C3_0F1E);
    reg_write(4'h4, 32'(BASE_PFN));
    reg_read(4'h4, d);
    check(d === 32'(BASE_PFN), "R2 base readback", d, 32'(BASE_PFN));
  endtask

  task automatic t_miss_hit();
    logic [31:0] pa; int rd, lat;
    xlate(page(3, 12'h123), pa, rd, lat);
    check(rd == 2, "R3 miss read count", 32'(rd), 32'd2);
    check(prev_addr === 32'h0004_0004, "R3 first read addr", prev_addr, 32'h0004_0004);
    check(last_addr === 32'h0010_100C, "R3 second read addr", last_addr, 32'h0010_100C);
    check(pa === exp_pa(page(3, 12'h123)), "R3 miss result", pa, exp_pa(page(3, 12'h123)));
    xlate(page(3, 12'hFFC), pa, rd, lat);
    check(rd == 0, "R5 hit no read", 32'(rd), 32'd0);
    check(lat == 1, "R5 hit latency", 32'(lat), 32'd1);
    check(pa === exp_pa(page(3, 12'hFFC)), "R5 hit result", pa, exp_pa(page(3, 12'hFFC)));
    xlate(32'h0140_7010, pa, rd, lat);
    check(pa === exp_pa(32'h0140_7010), "R3 second table result", pa, exp_pa(32'h0140_7010));
  endtask

  task automatic t_unmapped();
    logic [31:0] pa; int rd, lat;
    xlate(32'h0080_0123, pa, rd, lat);
    check(pa === {DUMMY_PG, 12'h123}, "R6 unmapped first level", pa, {DUMMY_PG, 12'h123});
    check(rd == 2, "R6 unmapped walks", 32'(rd), 32'd2);
    xlate(page(100, 12'hABC), pa, rd, lat);
    check(pa === {DUMMY_PG, 12'hABC}, "R6 unmapped second level", pa, {DUMMY_PG, 12'hABC});
  endtask

  task automatic t_round_robin();
    logic [31:0] pa; int rd, lat;
    reg_write(4'h0, 32'hFFFF_FFFF);
    for (int j = 0; j < 5; j++) xlate(page(j, 12'h010), pa, rd, lat);
    xlate(page(1, 12'h020), pa, rd, lat);
    check(rd == 0, "R7 page1 kept", 32'(rd), 32'd0);
    xlate(page(0, 12'h030), pa, rd, lat);
    check(rd == 2, "R7 oldest evicted", 32'(rd), 32'd2);
    check(pa === exp_pa(page(0, 12'h030)), "R7 refill result", pa, exp_pa(page(0, 12'h030)));
    xlate(page(4, 12'h040), pa, rd, lat);
    check(rd == 0, "R7 page4 kept", 32'(rd), 32'd0);
  endtask

  task automatic t_inval();
    logic [31:0] pa; int rd, lat;
    reg_write(4'h0, 32'h0000_0001);
    xlate(page(2, 12'h050), pa, rd, lat);
    check(rd == 0, "R8 other value ignored", 32'(rd), 32'd0);
    reg_write(4'h0, 32'hFFFF_FFFF);
    xlate(page(2, 12'h060), pa, rd, lat);
    check(rd == 2, "R8 invalidate forces walk", 32'(rd), 32'd2);
  endtask

  task automatic t_same_cycle();
    logic [31:0] pa; int rd, lat, r0;
    @(negedge clk);
    r0 = rd_count;
    req_valid = 1'b1; req_vaddr = page(2, 12'h070);
    reg_wr_en = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0; reg_wr_en = 1'b0;
    wait_rsp(r0, pa, rd, lat);
    check(rd == 2, "R9 same-cycle request walks", 32'(rd), 32'd2);
    check(pa === exp_pa(page(2, 12'h070)), "R9 result", pa, exp_pa(page(2, 12'h070)));
  endtask

  task automatic t_walk_flush();
    logic [31:0] pa; int rd, lat, r0;
    @(negedge clk);
    r0 = rd_count;
    req_valid = 1'b1; req_vaddr = page(9, 12'h2A0);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready === 1'b0, "R4 ready low during walk", 32'(req_ready), 32'd0);
    reg_wr_en = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr_en = 1'b0;
    wait_rsp(r0, pa, rd, lat);
    check(pa === exp_pa(page(9, 12'h2A0)), "R10 result delivered", pa, exp_pa(page(9, 12'h2A0)));
    xlate(page(9, 12'h2A4), pa, rd, lat);
    check(rd == 2, "R10 fill dropped", 32'(rd), 32'd2);
    xlate(page(9, 12'h2A8), pa, rd, lat);
    check(rd == 0, "R10 normal fill after", 32'(rd), 32'd0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] pa, d; int rd, lat;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 4'h4;
    #1 d = reg_rdata;
    check(d === 32'(BASE_PFN), "R11 base read", d, 32'(BASE_PFN));
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr_en = 1'b0;
    xlate(page(9, 12'h3B0), pa, rd, lat);
    check(rd == 2, "R11 walk after flushes", 32'(rd), 32'd2);
    check(pa === exp_pa(page(9, 12'h3B0)), "R11 result", pa, exp_pa(page(9, 12'h3B0)));
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0;
    reg_wr_en = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_miss_hit();
    t_unmapped();
    t_round_robin();
    t_inval();
    t_same_cycle();
    t_walk_flush();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule